// File: doc/BRIEF.md
# Indirect Pointer Shadow Register File

This block is the register-addressing front end of an 8051-style core. It holds a copy, inside the core, of the two pointer registers (R0 and R1) of each of the four register banks. Indirect `@Ri` operand addresses therefore come straight out of flip-flops and cost no extra internal-RAM read compared with plain `Rn` addressing. Every write that reaches the internal-RAM write bus is snooped. A write that lands on one of the eight pointer locations refreshes the matching copy in the same clock edge, so the copies never drift from RAM.

The block also works out the direct RAM address of an `Rn` operand from the opcode's register field and the active bank. The bank is tracked by snooping writes to the status word at SFR address D0h. The block executes the two-cycle "move immediate to indirect" instruction by itself. The first cycle accepts the opcode and its immediate byte. The second cycle drives the pointer and the byte onto the write bus for exactly one cycle. The most significant address bit steers that write to internal RAM or to the SFR space.

Other write traffic from the core enters on a valid/ready stream and is passed to the write bus when it is accepted. Both input streams are back-pressured only during the execute cycle of the move instruction. A producer must hold valid and its payload until ready is seen. A beat that is not accepted has no effect.

Top module: `ptr_shadow_frontend`

## Requirements
- R1: After reset all eight pointer copies read 00h and bank 0 is active, so `ri_ptr` is 00h and `rn_addr` equals `dec_reg`.
- R2: `rn_addr` is `{3'b000, bank[1:0], dec_reg[2:0]}` in every cycle, using the bank that is active in that cycle.
- R3: `ri_ptr` always equals the byte most recently written to internal RAM address `bank*8 + dec_reg[0]`, or 00h if that address has not been written since reset.
- R4: A committed internal-RAM write (`iram_we`) to 00h, 01h, 08h, 09h, 10h, 11h, 18h or 19h loads its byte into the matching copy at that clock edge. The copy index is bank = address bits 4:3 and register = address bit 0. A write to any other address changes no copy.
- R5: On the write bus, address bit 7 clear asserts `iram_we` and bit 7 set asserts `sfr_we`. The two strobes are never asserted together. An SFR write never changes a pointer copy, even when its low seven bits match a pointer location.
- R6: An SFR write to address D0h makes data bits 4:3 the active bank from the next cycle onward. The other data bits have no effect on addressing.
- R7: An accepted `ins_op` of 76h (R0) or 77h (R1) is followed by exactly one execute cycle. In that cycle `bus_addr` is the selected pointer copy of the bank then active, `bus_wdata` is the accepted immediate byte, and one strobe is asserted according to R5. The block is idle in the cycle after that.
- R8: `ins_ready` and `wr_ready` are low in the execute cycle and high in every other cycle after reset. An accepted `wr_valid` beat appears on the write bus in the same cycle. A beat that is not accepted has no effect.
- R9: An accepted `ins_op` other than 76h or 77h is consumed and causes no bus write and no execute cycle.
- R10: When the move instruction writes to a pointer location through `@Ri`, the matching copy is updated in the same edge, as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_reg | input | 3 | Register field (low opcode bits) of the instruction being decoded |
| rn_addr | output | 8 | Direct internal-RAM address of Rn for the active bank |
| ri_ptr | output | 8 | Indirect address held in R0/R1 (selected by `dec_reg[0]`) of the active bank |
| ins_valid | input | 1 | Instruction beat valid |
| ins_ready | output | 1 | Instruction beat accepted when high together with valid |
| ins_op | input | 8 | Opcode of the instruction beat |
| ins_imm | input | 8 | Immediate byte that follows the opcode |
| wr_valid | input | 1 | Core write request valid |
| wr_ready | output | 1 | Core write request accepted when high together with valid |
| wr_addr | input | 8 | Core write address (bit 7 selects SFR space) |
| wr_data | input | 8 | Core write data |
| bus_addr | output | 8 | Write bus address |
| bus_wdata | output | 8 | Write bus data |
| iram_we | output | 1 | Internal-RAM write strobe, write committed at the clock edge |
| sfr_we | output | 1 | SFR write strobe, write committed at the clock edge |

## Verification
A corrupted pointer copy stays hidden until `ri_ptr` selects it or a move instruction uses it. The error then shows at once as a mismatch against the RAM content at the bank-derived R0/R1 location. With `dec_reg` swept in every cycle, that mismatch appears within a few cycles of the faulty write. A wrong bank shows in `rn_addr` in the very next cycle after a status-word write. A sequencer fault shows as a missing, doubled or misrouted strobe, or as a ready that is wrong, in the cycle after an accepted opcode.

// File: rtl/ptrsh_pkg.sv
package ptrsh_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 8;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned SEL_W    = 1;
  localparam int unsigned BANK_LSB = 3;
  localparam logic [7:0]  PSW_ADDR = 8'hD0;
  localparam logic [7:0]  OP_MOVI  = 8'h76;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_EXEC = 1'b1
  } seq_state_e;

  typedef struct packed {
    logic          iram_we;
    logic          sfr_we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wbus_t;
endpackage

// File: rtl/ptrsh_bank_ctl.sv
module ptrsh_bank_ctl #(
  parameter int unsigned AW       = ptrsh_pkg::AW,
  parameter int unsigned BANK_W   = ptrsh_pkg::BANK_W,
  parameter logic [AW-1:0] PSW_AD = ptrsh_pkg::PSW_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cm_sfr_we,
  input  logic [AW-1:0]     cm_addr,
  input  logic [BANK_W-1:0] cm_bank_bits,
  output logic [BANK_W-1:0] bank_o
);
  logic [BANK_W-1:0] bank_q;
  logic              psw_hit;

  assign psw_hit = cm_sfr_we && (cm_addr == PSW_AD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (psw_hit) bank_q <= cm_bank_bits;
  end

  assign bank_o = bank_q;

  p_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    psw_hit |=> (bank_o == $past(cm_bank_bits)));

  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_hit |=> $stable(bank_o));
endmodule

// File: rtl/ptrsh_shadow_file.sv
module ptrsh_shadow_file #(
  parameter int unsigned AW       = ptrsh_pkg::AW,
  parameter int unsigned DW       = ptrsh_pkg::DW,
  parameter int unsigned BANK_W   = ptrsh_pkg::BANK_W,
  parameter int unsigned SEL_W    = ptrsh_pkg::SEL_W,
  parameter int unsigned BANK_LSB = ptrsh_pkg::BANK_LSB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cm_iram_we,
  input  logic                     cm_sfr_we,
  input  logic [AW-1:0]            cm_addr,
  input  logic [DW-1:0]            cm_data,
  input  logic [BANK_W+SEL_W-1:0]  rd_a_idx,
  input  logic [BANK_W+SEL_W-1:0]  rd_b_idx,
  output logic [DW-1:0]            rd_a_data,
  output logic [DW-1:0]            rd_b_data
);
  localparam int unsigned IDX_W  = BANK_W + SEL_W;
  localparam int unsigned NUM_SH = 1 << IDX_W;
  localparam int unsigned HI_LSB = BANK_LSB + BANK_W;

  logic [NUM_SH-1:0][DW-1:0] sh_q;
  logic                      in_window;
  logic                      hit;
  logic [IDX_W-1:0]          hit_idx;

  // Pointer locations: upper bits zero, gap bits between register and bank zero.
  assign in_window = (cm_addr[AW-1:HI_LSB] == '0) &&
                     (cm_addr[BANK_LSB-1:SEL_W] == '0);
  assign hit       = cm_iram_we && in_window;
  assign hit_idx   = {cm_addr[BANK_LSB +: BANK_W], cm_addr[SEL_W-1:0]};

  for (genvar g = 0; g < NUM_SH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  sh_q[g] <= '0;
      else if (hit && (hit_idx == IDX_W'(g)))      sh_q[g] <= cm_data;
    end
  end

  assign rd_a_data = sh_q[rd_a_idx];
  assign rd_b_data = sh_q[rd_b_idx];

  p_snoop_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (sh_q[$past(hit_idx)] == $past(cm_data)));

  p_miss_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_iram_we && !in_window) |=> $stable(sh_q));

  p_sfr_no_touch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cm_sfr_we |=> $stable(sh_q));
endmodule

// File: rtl/ptrsh_addr_gen.sv
module ptrsh_addr_gen #(
  parameter int unsigned AW       = ptrsh_pkg::AW,
  parameter int unsigned BANK_W   = ptrsh_pkg::BANK_W,
  parameter int unsigned SEL_W    = ptrsh_pkg::SEL_W,
  parameter int unsigned BANK_LSB = ptrsh_pkg::BANK_LSB
) (
  input  logic [BANK_W-1:0]        bank,
  input  logic [BANK_LSB-1:0]      dec_reg,
  input  logic [SEL_W-1:0]         seq_sel,
  output logic [AW-1:0]            rn_addr,
  output logic [BANK_W+SEL_W-1:0]  dec_idx,
  output logic [BANK_W+SEL_W-1:0]  seq_idx
);
  localparam int unsigned PAD_W = AW - BANK_W - BANK_LSB;

  assign rn_addr = {{PAD_W{1'b0}}, bank, dec_reg};
  assign dec_idx = {bank, dec_reg[SEL_W-1:0]};
  assign seq_idx = {bank, seq_sel};
endmodule

// File: rtl/ptrsh_mov_seq.sv
module ptrsh_mov_seq
  import ptrsh_pkg::*;
#(
  parameter int unsigned DW       = ptrsh_pkg::DW,
  parameter int unsigned SEL_W    = ptrsh_pkg::SEL_W,
  parameter logic [7:0]  OP_BASE  = ptrsh_pkg::OP_MOVI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_valid,
  input  logic [7:0]       ins_op,
  input  logic [DW-1:0]    ins_imm,
  output logic             ins_ready,
  output logic             exec_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [DW-1:0]    imm_o
);
  seq_state_e       st_q;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    imm_q;
  logic             take;
  logic             is_movi;

  assign is_movi   = (ins_op[7:SEL_W] == OP_BASE[7:SEL_W]);
  assign ins_ready = (st_q == SEQ_IDLE);
  assign take      = ins_valid && ins_ready && is_movi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      sel_q <= '0;
      imm_q <= '0;
    end else begin
      case (st_q)
        SEQ_IDLE: if (take) begin
          st_q  <= SEQ_EXEC;
          sel_q <= ins_op[SEL_W-1:0];
          imm_q <= ins_imm;
        end
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign exec_o = (st_q == SEQ_EXEC);
  assign sel_o  = sel_q;
  assign imm_o  = imm_q;

  p_exec_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> !exec_o);

  p_take_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && is_movi) |=> (exec_o && imm_o == $past(ins_imm)));

  p_other_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !is_movi) |=> !exec_o);
endmodule

// File: rtl/ptr_shadow_frontend.sv
module ptr_shadow_frontend
  import ptrsh_pkg::*;
#(
  parameter int unsigned AW       = ptrsh_pkg::AW,
  parameter int unsigned DW       = ptrsh_pkg::DW,
  parameter int unsigned BANK_W   = ptrsh_pkg::BANK_W,
  parameter int unsigned SEL_W    = ptrsh_pkg::SEL_W,
  parameter int unsigned BANK_LSB = ptrsh_pkg::BANK_LSB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BANK_LSB-1:0] dec_reg,
  output logic [AW-1:0]       rn_addr,
  output logic [DW-1:0]       ri_ptr,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [7:0]          ins_op,
  input  logic [DW-1:0]       ins_imm,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [AW-1:0]       wr_addr,
  input  logic [DW-1:0]       wr_data,
  output logic [AW-1:0]       bus_addr,
  output logic [DW-1:0]       bus_wdata,
  output logic                iram_we,
  output logic                sfr_we
);
  localparam int unsigned IDX_W = BANK_W + SEL_W;

  logic [BANK_W-1:0] bank;
  logic              exec;
  logic [SEL_W-1:0]  seq_sel;
  logic [DW-1:0]     seq_imm;
  logic [IDX_W-1:0]  dec_idx;
  logic [IDX_W-1:0]  seq_idx;
  logic [DW-1:0]     seq_ptr;
  wbus_t             cm;

  ptrsh_mov_seq #(.DW(DW), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_op(ins_op), .ins_imm(ins_imm),
    .ins_ready(ins_ready), .exec_o(exec), .sel_o(seq_sel), .imm_o(seq_imm)
  );

  ptrsh_addr_gen #(.AW(AW), .BANK_W(BANK_W), .SEL_W(SEL_W), .BANK_LSB(BANK_LSB)) u_agen (
    .bank(bank), .dec_reg(dec_reg), .seq_sel(seq_sel),
    .rn_addr(rn_addr), .dec_idx(dec_idx), .seq_idx(seq_idx)
  );

  // Write bus: the execute cycle owns it, otherwise an accepted core write.
  always_comb begin
    cm = '0;
    if (exec) begin
      cm.addr    = AW'(seq_ptr);
      cm.data    = seq_imm;
      cm.iram_we = !seq_ptr[DW-1];
      cm.sfr_we  = seq_ptr[DW-1];
    end else begin
      cm.addr    = wr_addr;
      cm.data    = wr_data;
      cm.iram_we = wr_valid && !wr_addr[AW-1];
      cm.sfr_we  = wr_valid && wr_addr[AW-1];
    end
  end

  assign wr_ready  = !exec;
  assign bus_addr  = cm.addr;
  assign bus_wdata = cm.data;
  assign iram_we   = cm.iram_we;
  assign sfr_we    = cm.sfr_we;

  ptrsh_shadow_file #(.AW(AW), .DW(DW), .BANK_W(BANK_W), .SEL_W(SEL_W),
                      .BANK_LSB(BANK_LSB)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .cm_iram_we(cm.iram_we), .cm_sfr_we(cm.sfr_we),
    .cm_addr(cm.addr), .cm_data(cm.data),
    .rd_a_idx(dec_idx), .rd_b_idx(seq_idx),
    .rd_a_data(ri_ptr), .rd_b_data(seq_ptr)
  );

  ptrsh_bank_ctl #(.AW(AW), .BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cm_sfr_we(cm.sfr_we), .cm_addr(cm.addr),
    .cm_bank_bits(cm.data[BANK_LSB +: BANK_W]),
    .bank_o(bank)
  );

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(iram_we && sfr_we));

  p_mov_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_op[7:1] == OP_MOVI[7:1]) |=> (iram_we || sfr_we) && !wr_ready);

  p_ready_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_ready |=> ins_ready);
endmodule

// File: tb/ptr_shadow_frontend_tb.sv
module ptr_shadow_frontend_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] dec_reg;
  logic [7:0] rn_addr, ri_ptr;
  logic       ins_valid, ins_ready;
  logic [7:0] ins_op, ins_imm;
  logic       wr_valid, wr_ready;
  logic [7:0] wr_addr, wr_data;
  logic [7:0] bus_addr, bus_wdata;
  logic       iram_we, sfr_we;

  always #10 clk = ~clk;

  ptr_shadow_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .dec_reg(dec_reg), .rn_addr(rn_addr), .ri_ptr(ri_ptr),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_op(ins_op), .ins_imm(ins_imm),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .iram_we(iram_we), .sfr_we(sfr_we)
  );

  // RAM stub fed by the design's own bus writes
  logic [7:0] stub [256];
  initial for (int i = 0; i < 256; i++) stub[i] = 8'h00;
  always @(posedge clk) if (iram_we) stub[bus_addr] <= bus_wdata;

  int tests = 0, fails = 0;
  int m_bank = 0;
  bit m_busy = 0, m_sel = 0;
  logic [7:0] m_imm = 8'h00;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit iv, input logic [7:0] iop, input logic [7:0] iimm,
                      input bit wv, input logic [7:0] wa, input logic [7:0] wd,
                      input logic [2:0] dr);
    logic [7:0] ptr, ea, ed;
    bit ei, es;
    @(negedge clk);
    ins_valid = iv; ins_op = iop; ins_imm = iimm;
    wr_valid = wv; wr_addr = wa; wr_data = wd; dec_reg = dr;
    #2;
    ptr = stub[m_bank*8 + int'(m_sel)];
    ei = 0; es = 0; ea = 8'h00; ed = 8'h00;
    chk("R8", "ins_ready", ins_ready, !m_busy);
    chk("R8", "wr_ready", wr_ready, !m_busy);
    if (m_busy) begin
      ea = ptr; ed = m_imm; ei = !ptr[7]; es = ptr[7];
      chk("R7", "exec bus_addr", bus_addr, ea);
      chk("R7", "exec bus_wdata", bus_wdata, ed);
    end else if (wv) begin
      ea = wa; ed = wd; ei = !wa[7]; es = wa[7];
      chk("R8", "pass bus_addr", bus_addr, ea);
      chk("R8", "pass bus_wdata", bus_wdata, ed);
    end
    chk("R5", "iram_we", iram_we, ei);
    chk("R5", "sfr_we", sfr_we, es);
    chk("R3", "ri_ptr", ri_ptr, stub[m_bank*8 + int'(dr[0])]);
    chk("R2", "rn_addr", rn_addr, 8'(m_bank*8 + int'(dr)));
    @(posedge clk);
    if (es && ea == 8'hD0) m_bank = int'(ed[4:3]);
    if (m_busy) m_busy = 0;
    else if (iv && iop[7:1] == 7'h3B) begin
      m_busy = 1; m_imm = iimm; m_sel = iop[0];
    end
    #1;
  endtask

  task automatic idle(input logic [2:0] dr);
    step(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, dr);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [2:0] dr);
    step(0, 8'h00, 8'h00, 1, a, d, dr);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; ins_valid = 0; ins_op = 0; ins_imm = 0;
    wr_valid = 0; wr_addr = 0; wr_data = 0; dec_reg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    idle(3'd1);
    chk("R1", "ri_ptr R1 bank0", ri_ptr, 8'h00);
    idle(3'd5);
    chk("R1", "rn_addr bank0", rn_addr, 8'h05);
    chk("R1", "ins_ready", ins_ready, 1'b1);

    // R4: pointer location write updates copy; other address does not
    wr(8'h11, 8'hA5, 3'd1);
    wr(8'hD0, 8'h10, 3'd1);            // bank 2
    idle(3'd1);
    chk("R4", "bank2 R1 copy", ri_ptr, 8'hA5);
    wr(8'h12, 8'h77, 3'd1);
    chk("R4", "non-pointer write", ri_ptr, 8'hA5);

    // R5: SFR write with matching low bits leaves copies untouched
    wr(8'h91, 8'h3C, 3'd1);
    chk("R5", "sfr alias", ri_ptr, 8'hA5);

    // R6: only bits 4:3 of the status word select the bank
    wr(8'hD0, 8'hE7, 3'd3);
    chk("R6", "bank0 after E7", rn_addr, 8'h03);
    wr(8'hD0, 8'h18, 3'd6);
    chk("R6", "bank3", rn_addr, 8'h1E);

    // R9: other opcode consumed, no write follows
    step(1, 8'h78, 8'h55, 0, 8'h00, 8'h00, 3'd0);
    chk("R9", "ready after other op", ins_ready, 1'b1);
    idle(3'd0);

    // R7 / R10: move through R0 of bank 3 into R1 location of bank 3
    wr(8'h18, 8'h19, 3'd1);
    step(1, 8'h76, 8'h4B, 0, 8'h00, 8'h00, 3'd1);
    idle(3'd1);
    chk("R10", "R1 copy after @R0 write", ri_ptr, 8'h4B);
    chk("R7", "stub 19h", stub[8'h19], 8'h4B);

    // R7: move through R1 into the status word (SFR) -> bank 1
    wr(8'h19, 8'hD0, 3'd0);
    step(1, 8'h77, 8'h08, 0, 8'h00, 8'h00, 3'd0);
    idle(3'd0);
    chk("R7", "bank via @R1 SFR write", rn_addr, 8'h08);

    // R8: core write held during execute cycle
    step(1, 8'h77, 8'h21, 1, 8'h09, 8'h66, 3'd1);
    step(0, 8'h00, 8'h00, 1, 8'h09, 8'h66, 3'd1);
    step(0, 8'h00, 8'h00, 1, 8'h09, 8'h66, 3'd1);
    idle(3'd1);
    chk("R8", "held write landed", ri_ptr, 8'h66);

    // random traffic compared every cycle
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op, a;
      int k;
      op = ($urandom % 2 == 0) ? (8'h76 | 8'($urandom % 2)) : 8'($urandom);
      k = int'($urandom % 12);
      case (k)
        0: a = 8'h00; 1: a = 8'h01; 2: a = 8'h08; 3: a = 8'h09;
        4: a = 8'h10; 5: a = 8'h11; 6: a = 8'h18; 7: a = 8'h19;
        8: a = 8'hD0; default: a = 8'($urandom);
      endcase
      step($urandom % 3 == 0, op, 8'($urandom), $urandom % 2 == 0, a,
           8'($urandom), 3'($urandom));
    end

    summary();
    $finish;
  end
endmodule